// File: doc/BRIEF.md
# Region Chip-Select Decoder with Programmable Bus Acknowledge

This block sits beside a 16-bit asynchronous-bus processor that has four programmable region selects of its own. Within each active region it decodes two upper address bits and drives one active-low device select per used sub-window. It also produces the bus acknowledge for the cycle. Each region has a fixed policy for that acknowledge:

| Region | Size | Acknowledge |
|---|---|---|
| 0 | 4 MB | internal, no wait states |
| 1 | 2 MB | taken from external logic |
| 2 | 2 MB | internal, after six wait states |
| 3 | 2 MB | internal, after two wait states |

The block also turns the processor's read/write line and its two byte strobes into four separate strobes: read-upper, read-lower, write-upper and write-lower.

Only the address bits the block decodes come in. Those are byte-address bits 21 down to 19, presented as `a_hi[2:0]`. An access that hits no region never receives an acknowledge, so a bus-error timer elsewhere in the system can catch it.

Top module: `csdec_top`

## Requirements
- R1: The device selects are indexed as follows.
  - Region 0 decodes `a_hi[2:1]` (sub-window 0 drives index 0, 1 drives index 1, 2 drives index 2).
  - Region 1 decodes `a_hi[1:0]` (sub 0 drives index 3, sub 1 drives index 4).
  - Region 2 decodes `a_hi[1:0]` (subs 0..3 drive indices 5..8).
  - Region 3 decodes `a_hi[1:0]` (subs 0..3 drive indices 9..12).
  - A select is driven low only while `as_n` is low.
- R2: Unused sub-windows assert no device select. These are region 0 sub 3, and region 1 subs 2 and 3.
- R3: While `as_n` is high, every device select and every byte strobe is high.
- R4: At most one device select is low at any time.
- R5: When several region selects are low together, the lowest-numbered region wins.
- R6: A region-0 access drives `dtack_n` low in the same cycle in which `as_n` is low, with no clock edge needed.
- R7: In a region-2 access, `dtack_n` goes low after the sixth rising clock edge with `as_n` low. In a region-3 access, it goes low after the second such edge. Before that, `dtack_n` stays high.
- R8: During a region-1 access, `dtack_n` equals `ext_dtack_n`.
- R9: Once asserted, `dtack_n` stays low until `as_n` rises. At that point it goes high at once, and the next access counts its wait states from zero again.
- R10: With all region selects high, `dtack_n` stays high whatever the other inputs do.
- R11: Each strobe goes low only in the following case, with `as_n` also low:
  - `rd_hi_n` = read with `uds_n` low;
  - `rd_lo_n` = read with `lds_n` low;
  - `wr_hi_n` = write with `uds_n` low;
  - `wr_lo_n` = write with `lds_n` low.
  - Read means `rw`=1; write means `rw`=0.
- R12: While `rst_n` is low (synchronous), the wait-state count is held at zero. A region-2 access therefore receives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 4 | Active-low region selects, bit r for region r |
| a_hi | input | 3 | Byte-address bits 21..19 |
| as_n | input | 1 | Active-low address strobe |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Active-low upper data strobe |
| lds_n | input | 1 | Active-low lower data strobe |
| ext_dtack_n | input | 1 | Acknowledge from external logic, used for region 1 |
| dev_sel_n | output | 13 | Active-low device selects (map in R1) |
| rd_hi_n | output | 1 | Upper-byte read strobe |
| rd_lo_n | output | 1 | Lower-byte read strobe |
| wr_hi_n | output | 1 | Upper-byte write strobe |
| wr_lo_n | output | 1 | Lower-byte write strobe |
| dtack_n | output | 1 | Data-transfer acknowledge to the processor |

## Verification
The assertions check the following on every cycle:
- selects and strobes are idle while the address strobe is high;
- at most one select is low;
- no acknowledge is given without a region;
- the zero-wait acknowledge of region 0 is immediate;
- the first cycle of a region-2 access is not acknowledged;
- a region-2 acknowledge is held while the strobe stays low;
- no strobe asserts in a direction or byte lane that was not requested.

The bench scenarios show the rest:
- the exact device index for every region and sub-window;
- the exact edge at which the six- and two-wait acknowledges appear;
- the external pass-through;
- region priority;
- the counter restarting between back-to-back accesses and being held during reset.

// File: rtl/csdec_pkg.sv
// Package: device map shared by the decoder, the bench and the checker.
// Assumes four regions, with devices numbered consecutively region by region.
package csdec_pkg;
    localparam int NREG = 4;
    localparam int NDEV = 13;

    // Number of device selects used inside region r.
    function automatic int dev_count(input int r);
        case (r)
            0:       return 3;
            1:       return 2;
            default: return 4;
        endcase
    endfunction

    // Index of the first device select belonging to region r.
    function automatic int dev_base(input int r);
        case (r)
            0:       return 0;
            1:       return 3;
            2:       return 5;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/csdec_region.sv
// Region resolver and device decoder.
// Picks the lowest-numbered active region select, extracts that region's two
// sub-window bits, and drives one active-low device select per used sub-window.
// Assumes the region-0 window is at least as large as the other regions.
module csdec_region
    import csdec_pkg::*;
#(
    parameter int HI_W = 3
) (
    input  logic [3:0]      cs_n,
    input  logic [HI_W-1:0] a_hi,
    input  logic            as_n,
    output logic            hit,
    output logic [1:0]      idx,
    output logic [NDEV-1:0] dev_sel_n
);
    logic [1:0] sub;

    // Priority resolve: the loop runs downward, so the lowest active region is assigned last and wins.
    always_comb begin
        hit = 1'b0;
        idx = 2'd0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (!cs_n[r]) begin
                hit = 1'b1;
                idx = 2'(r);
            end
        end
    end

    // Sub-window bits: region 0 uses the top pair of a_hi, the others use the bottom pair.
    always_comb begin
        sub = (idx == 2'd0) ? a_hi[HI_W-1 -: 2] : a_hi[1:0];
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam int CNT  = dev_count(r);
        localparam int BASE = dev_base(r);
        for (genvar d = 0; d < CNT; d++) begin : g_dev
            assign dev_sel_n[BASE + d] =
                !(!as_n && hit && (idx == 2'(r)) && (sub == 2'(d)));
        end
    end
endmodule

// File: rtl/csdec_ack.sv
// Acknowledge generator.
// Counts rising edges while the address strobe is low inside a region, and
// acknowledges once the region's wait count is reached. Regions flagged in
// EXT_MASK pass the external acknowledge through instead.
// Assumes every wait value is at most 2**CNT_W - 1.
module csdec_ack #(
    parameter int         WAIT_R0  = 0,
    parameter int         WAIT_R1  = 0,
    parameter int         WAIT_R2  = 6,
    parameter int         WAIT_R3  = 2,
    parameter logic [3:0] EXT_MASK = 4'b0010,
    parameter int         CNT_W    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       hit,
    input  logic [1:0] idx,
    input  logic       ext_dtack_n,
    output logic       dtack_n
);
    logic [CNT_W-1:0] cnt;
    int               wait_sel;
    logic             ack_int;

    // Wait count of the region currently being accessed.
    always_comb begin
        case (idx)
            2'd0:    wait_sel = WAIT_R0;
            2'd1:    wait_sel = WAIT_R1;
            2'd2:    wait_sel = WAIT_R2;
            default: wait_sel = WAIT_R3;
        endcase
    end

    // Wait-state counter: advances and saturates during an access, clears otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!as_n && hit) begin
            if (cnt != '1)
                cnt <= cnt + 1'b1;
        end else
            cnt <= '0;
    end

    // Internal acknowledge is ready once the counter reaches the region's wait count.
    always_comb ack_int = (int'(cnt) >= wait_sel);

    // Drive the acknowledge: gated by strobe and region, internal or external by policy.
    always_comb begin
        dtack_n = !(!as_n && hit && (EXT_MASK[idx] ? !ext_dtack_n : ack_int));
    end
endmodule

// File: rtl/csdec_strobe.sv
// Byte-lane strobe splitter.
// Combines the address strobe, the direction line and the two data strobes
// into separate upper and lower read and write strobes, all active-low.
module csdec_strobe (
    input  logic as_n,
    input  logic rw,
    input  logic uds_n,
    input  logic lds_n,
    output logic rd_hi_n,
    output logic rd_lo_n,
    output logic wr_hi_n,
    output logic wr_lo_n
);
    // Qualify each byte lane by the address strobe and the transfer direction.
    always_comb begin
        rd_hi_n = !(!as_n &&  rw && !uds_n);
        rd_lo_n = !(!as_n &&  rw && !lds_n);
        wr_hi_n = !(!as_n && !rw && !uds_n);
        wr_lo_n = !(!as_n && !rw && !lds_n);
    end
endmodule

// File: rtl/csdec_top.sv
// Top: region chip-select decoder with a programmable acknowledge per region.
// Assumes the bus signals are synchronous to clk. Region 0 spans 2**REG0_LOG2
// bytes and the other regions span 2**REGX_LOG2 bytes. a_hi carries the
// byte-address bits REG0_LOG2-1 down to REGX_LOG2-2.
module csdec_top
    import csdec_pkg::*;
#(
    parameter int         REG0_LOG2 = 22,
    parameter int         REGX_LOG2 = 21,
    parameter int         WAIT_R0   = 0,
    parameter int         WAIT_R2   = 6,
    parameter int         WAIT_R3   = 2,
    parameter logic [3:0] EXT_MASK  = 4'b0010,
    localparam int        HI_W      = REG0_LOG2 - REGX_LOG2 + 2,
    localparam int        MAX_WAIT  = (WAIT_R2 > WAIT_R3) ?
                                      ((WAIT_R2 > WAIT_R0) ? WAIT_R2 : WAIT_R0) :
                                      ((WAIT_R3 > WAIT_R0) ? WAIT_R3 : WAIT_R0),
    localparam int        CNT_W     = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      cs_n,
    input  logic [HI_W-1:0] a_hi,
    input  logic            as_n,
    input  logic            rw,
    input  logic            uds_n,
    input  logic            lds_n,
    input  logic            ext_dtack_n,
    output logic [NDEV-1:0] dev_sel_n,
    output logic            rd_hi_n,
    output logic            rd_lo_n,
    output logic            wr_hi_n,
    output logic            wr_lo_n,
    output logic            dtack_n
);
    logic       hit;
    logic [1:0] idx;

    csdec_region #(.HI_W(HI_W)) u_region (
        .cs_n      (cs_n),
        .a_hi      (a_hi),
        .as_n      (as_n),
        .hit       (hit),
        .idx       (idx),
        .dev_sel_n (dev_sel_n)
    );

    csdec_ack #(
        .WAIT_R0  (WAIT_R0),
        .WAIT_R1  (0),
        .WAIT_R2  (WAIT_R2),
        .WAIT_R3  (WAIT_R3),
        .EXT_MASK (EXT_MASK),
        .CNT_W    (CNT_W)
    ) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n        (as_n),
        .hit         (hit),
        .idx         (idx),
        .ext_dtack_n (ext_dtack_n),
        .dtack_n     (dtack_n)
    );

    csdec_strobe u_strobe (
        .as_n    (as_n),
        .rw      (rw),
        .uds_n   (uds_n),
        .lds_n   (lds_n),
        .rd_hi_n (rd_hi_n),
        .rd_lo_n (rd_lo_n),
        .wr_hi_n (wr_hi_n),
        .wr_lo_n (wr_lo_n)
    );
endmodule

// File: rtl/csdec_checker.sv
// Checker: cycle-by-cycle properties of csdec_top, attached by bind.
// Assumes the default region policy: region 0 has zero waits, region 2 has six.
module csdec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cs_n,
    input logic        as_n,
    input logic        rw,
    input logic        uds_n,
    input logic        lds_n,
    input logic [12:0] dev_sel_n,
    input logic        rd_hi_n,
    input logic        rd_lo_n,
    input logic        wr_hi_n,
    input logic        wr_lo_n,
    input logic        dtack_n
);
    // R3: an idle address strobe leaves every select and strobe inactive.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (&dev_sel_n && rd_hi_n && rd_lo_n && wr_hi_n && wr_lo_n));

    // R4: never more than one device selected.
    assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dev_sel_n));

    // R10: no acknowledge without a region.
    assert_no_region_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> dtack_n);

    // R6: region 0 is acknowledged whenever it is strobed.
    assert_zero_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !cs_n[0]) |-> !dtack_n);

    // R7: the first strobed cycle of a region-2 access is not yet acknowledged.
    assert_r2_not_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && cs_n == 4'b1011 && $past(as_n)) |-> dtack_n);

    // R9: a region-2 acknowledge holds while the same access continues.
    assert_ack_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !dtack_n && cs_n == 4'b1011) |=>
            (as_n || cs_n != 4'b1011 || !dtack_n));

    // R11: a strobe asserts only for the requested direction and byte lane.
    assert_strobe_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi_n |-> (rw && !uds_n)) and (!rd_lo_n |-> (rw && !lds_n)) and
        (!wr_hi_n |-> (!rw && !uds_n)) and (!wr_lo_n |-> (!rw && !lds_n)));
endmodule

bind csdec_top csdec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .as_n      (as_n),
    .rw        (rw),
    .uds_n     (uds_n),
    .lds_n     (lds_n),
    .dev_sel_n (dev_sel_n),
    .rd_hi_n   (rd_hi_n),
    .rd_lo_n   (rd_lo_n),
    .wr_hi_n   (wr_hi_n),
    .wr_lo_n   (wr_lo_n),
    .dtack_n   (dtack_n)
);

// File: tb/sim_csdec_top.sv
// Bench: sweeps regions, sub-windows, strobe combinations and wait timing.
// Expected values are computed arithmetically from the requirements.
module sim_csdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cs_n = 4'hF;
    logic [2:0]  a_hi = 3'd0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic        ext_dtack_n = 1'b1;
    logic [12:0] dev_sel_n;
    logic        rd_hi_n, rd_lo_n, wr_hi_n, wr_lo_n, dtack_n;
    int          total = 0;
    int          bad = 0;

    csdec_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a_hi(a_hi), .as_n(as_n),
        .rw(rw), .uds_n(uds_n), .lds_n(lds_n), .ext_dtack_n(ext_dtack_n),
        .dev_sel_n(dev_sel_n), .rd_hi_n(rd_hi_n), .rd_lo_n(rd_lo_n),
        .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n), .dtack_n(dtack_n)
    );

    always #10 clk = ~clk;

    // Record one check; print a line on mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected select vector for a region/sub pair (R1/R2 map).
    function automatic logic [12:0] exp_sel(input int r, input int s);
        int cnt;
        int base;
        cnt  = (r == 0) ? 3 : (r == 1) ? 2 : 4;
        base = (r == 0) ? 0 : (r == 1) ? 3 : (r == 2) ? 5 : 9;
        exp_sel = 13'h1FFF;
        if (s < cnt) exp_sel[base + s] = 1'b0;
    endfunction

    // Address bits placing sub-window s in region r, with a filler bit.
    function automatic logic [2:0] addr_for(input int r, input int s, input logic fill);
        if (r == 0) addr_for = {2'(s), fill};
        else        addr_for = {fill, 2'(s)};
    endfunction

    // Idle the bus for two cycles: inputs change after negedge.
    task automatic idle();
        @(negedge clk);
        as_n = 1'b1; cs_n = 4'hF; uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk);
    endtask

    // Start an access at a negedge, then wait 1 ns before sampling.
    task automatic start(input logic [3:0] cs, input logic [2:0] a);
        @(negedge clk);
        cs_n = cs; a_hi = a; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        #1;
    endtask

    // Run an access of region r, expecting the acknowledge after w edges.
    task automatic wait_seq(input int r, input int w, input string req);
        start(~(4'b1 << r), 3'd0);
        for (int k = 0; k <= w + 1; k++) begin
            chk(req, {31'd0, dtack_n}, {31'd0, (k >= w) ? 1'b0 : 1'b1});
            @(negedge clk); #1;
        end
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12: a region-2 access during reset is never acknowledged.
        start(4'b1011, 3'd0);
        repeat (10) @(negedge clk);
        #1 chk("R12", {31'd0, dtack_n}, 32'd1);
        chk("R3", {19'd0, dev_sel_n}, {19'd0, exp_sel(2, 0)});
        idle();
        rst_n = 1'b1;
        #1 chk("R3", {19'd0, dev_sel_n}, 32'h1FFF);

        // R1/R2: every region, every sub-window, both filler values.
        for (int r = 0; r < 4; r++)
            for (int s = 0; s < 4; s++)
                for (int f = 0; f < 2; f++) begin
                    start(~(4'b1 << r), addr_for(r, s, f[0]));
                    chk((s >= ((r == 0) ? 3 : (r == 1) ? 2 : 4)) ? "R2" : "R1",
                        {19'd0, dev_sel_n}, {19'd0, exp_sel(r, s)});
                    @(negedge clk); as_n = 1'b1; #1;
                    chk("R3", {19'd0, dev_sel_n}, 32'h1FFF);
                    idle();
                end

        // R5: every multi-select pattern resolves to the lowest region.
        for (int m = 1; m < 16; m++) begin
            int low;
            low = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) low = b;
            start(~4'(m), addr_for(low, 1, 1'b0));
            chk("R5", {19'd0, dev_sel_n}, {19'd0, exp_sel(low, 1)});
            idle();
        end

        // R6/R7/R9: wait timing per region, twice for back-to-back restart.
        for (int rep = 0; rep < 2; rep++) begin
            wait_seq(0, 0, "R6");
            wait_seq(2, 6, "R7");
            wait_seq(3, 2, (rep == 0) ? "R7" : "R9");
        end

        // R9: release on strobe rise is immediate.
        start(4'b0111, 3'd0);
        repeat (3) @(negedge clk);
        #1 chk("R9", {31'd0, dtack_n}, 32'd0);
        as_n = 1'b1; #1;
        chk("R9", {31'd0, dtack_n}, 32'd1);
        idle();

        // R8: region 1 follows the external acknowledge, regardless of elapsed cycles.
        start(4'b1101, 3'd0);
        for (int k = 0; k < 8; k++) begin
            ext_dtack_n = k[0]; #1;
            chk("R8", {31'd0, dtack_n}, {31'd0, k[0]});
            @(negedge clk);
        end
        ext_dtack_n = 1'b1;
        idle();

        // R10: no region selected, all other inputs swept.
        @(negedge clk);
        cs_n = 4'hF; as_n = 1'b0;
        for (int k = 0; k < 16; k++) begin
            ext_dtack_n = k[0]; rw = k[1]; uds_n = k[2]; lds_n = k[3];
            a_hi = 3'(k);
            #1 chk("R10", {31'd0, dtack_n}, 32'd1);
            chk("R10", {19'd0, dev_sel_n}, 32'h1FFF);
            @(negedge clk);
        end
        idle();

        // R11/R3: exhaustive strobe combinations.
        for (int k = 0; k < 16; k++) begin
            logic a, d, u, l;
            logic [3:0] e;
            {a, d, u, l} = 4'(k);
            @(negedge clk);
            as_n = a; rw = d; uds_n = u; lds_n = l; cs_n = 4'b1110;
            e[3] = !(!a &&  d && !u);
            e[2] = !(!a &&  d && !l);
            e[1] = !(!a && !d && !u);
            e[0] = !(!a && !d && !l);
            #1 chk(a ? "R3" : "R11", {28'd0, rd_hi_n, rd_lo_n, wr_hi_n, wr_lo_n},
                   {28'd0, e});
        end
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule